// File: doc/BRIEF.md
# Raster Timing Generator

The block produces the master raster timing for standard-definition analog video in either the 525-line, 59.94 Hz standard (NTSC) or the 625-line, 50 Hz standard (PAL). It runs on the 13.5 MHz sample clock and keeps a position counter within the line and a line counter within the frame. Every timing output is decoded from those two counters. The outputs are an active-low horizontal sync pulse at a programmable offset, a one-clock vertical datum strobe, a field flag, a vertical blanking gate, a clamp/burst line gate and an NTSC set-up (pedestal) window.

A one-bit format select picks the line length, the frame length and every line window. An upstream pixel source can align its first chroma sample to the line by moving the sync edge with the 10-bit offset. The current counter values are also brought out, so that neighbouring logic can decode further positions from them.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel position counts 0 to L-1 and then returns to 0. L is `L_NTSC` (default 858) when `fmt_pal`=0 and `L_PAL` (default 864) when `fmt_pal`=1.
- R2: The line number advances by one as the pixel position returns to 0. After the last line (525 for NTSC, 625 for PAL) it goes back to 1.
- R3: `field` is 0 on lines below the boundary line and 1 from the boundary line to the last line. The boundary line is 264 for NTSC and 313 for PAL.
- R4: In NTSC, `vblank` is 1 on lines 1–9 and 264–272, and on line 263 from pixel L/2 onward. It is 0 at every other position.
- R5: In PAL, `vblank` is 1 on lines 1–5, 311–318 and 624–625, and on line 623 from pixel L/2 onward. It is 0 at every other position.
- R6: `clamp_gate` is 1 for whole lines. These are lines 10–263 and 273–525 in NTSC, and lines 6–310 and 319–623 in PAL.
- R7: `ped_win` is 1 only when `fmt_pal`=0 and `ped_en`=1, on lines 23–262 and 286–525. In PAL, `ped_en` has no effect and `ped_win` stays 0.
- R8: `hs_n` falls at pixel F. F is (`hs_offset` + L − `HS_REF`) mod L, and F is limited to L−1 when that sum is 2L or more. An offset equal to `HS_REF` (default 126, 0x07E) puts the fall at pixel 0, and a smaller offset moves it earlier.
- R9: `hs_n` stays low for `HS_W` clocks (default 64). If the pulse would run past pixel L−1, it is cut off at the line end and does not continue into the next line.
- R10: `vs` is high for exactly one clock per field. In NTSC this is at pixel 0 of line 4 and at pixel L/2 of line 266. In PAL it is at pixel 0 of line 1 and at pixel L/2 of line 313.
- R11: While `rst_n` is low at a clock edge, the counters load pixel 0 of line 64. The decoded outputs then reflect that position, with `field`=0 and `clamp_gate`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_pal | input | 1 | Format select: 0 = 525-line, 1 = 625-line |
| ped_en | input | 1 | Enables the set-up window in the 525-line format |
| hs_offset | input | OFF_W (10) | Horizontal sync placement offset |
| hs_n | output | 1 | Active-low horizontal sync |
| vs | output | 1 | One-clock field datum strobe |
| field | output | 1 | Field flag, 1 in the second field |
| vblank | output | 1 | Vertical blanking gate |
| clamp_gate | output | 1 | Clamp/burst line gate |
| ped_win | output | 1 | Pedestal line window |
| line_num | output | 10 | Current line, 1-based |
| pix_pos | output | PIX_W (10) | Current pixel within the line |

## Verification
The bench shortens the lines (40 and 44 clocks, with an 8-clock sync and a reference of 10), so that whole frames fit in a short run. Every clock it compares all outputs against a position model computed inside the bench. One full frame from reset is swept in each format and in both pedestal settings. This separates the two standards' window tables and the half-line blanking, and it shows that the pedestal enable is ignored in PAL. A sweep of the offset from 0 to 127 and the maximum value 1023 covers three cases: normal placement, pulses cut off at the line end, and the clamped fall position.

// File: rtl/raster_pkg.sv
// raster_pkg: line numbers of the two supported raster standards.
// Assumes lines are numbered from 1 and fit in LINE_W bits.
package raster_pkg;
    localparam int LINE_W = 10;
    typedef logic [LINE_W-1:0] line_t;

    localparam line_t RESET_LINE = 10'd64;
    localparam line_t PED_A_LO   = 10'd23;
    localparam line_t PED_A_HI   = 10'd262;
    localparam line_t PED_B_LO   = 10'd286;
    localparam line_t PED_B_HI   = 10'd525;

    // Window bounds used by the vertical decoder
    typedef struct packed {
        line_t blk_top_hi;   // blanked from line 1 up to here
        line_t blk_mid_lo;   // second blanked band, low bound
        line_t blk_mid_hi;   // second blanked band, high bound
        line_t blk_end_lo;   // blanked from here to the last line
        line_t half_ln;      // line blanked only in its second half
        line_t clp_a_lo;
        line_t clp_a_hi;
        line_t clp_b_lo;
        line_t clp_b_hi;
        line_t vs_a_ln;      // datum at start of line
        line_t vs_b_ln;      // datum at middle of line
    } win_lines_t;

    function automatic line_t last_line(input logic pal);
        return pal ? 10'd625 : 10'd525;
    endfunction

    function automatic line_t field_line(input logic pal);
        return pal ? 10'd313 : 10'd264;
    endfunction

    function automatic win_lines_t win_lines(input logic pal);
        win_lines_t w;
        if (pal) begin
            w = '{blk_top_hi: 10'd5,   blk_mid_lo: 10'd311, blk_mid_hi: 10'd318,
                  blk_end_lo: 10'd624, half_ln:    10'd623,
                  clp_a_lo:   10'd6,   clp_a_hi:   10'd310,
                  clp_b_lo:   10'd319, clp_b_hi:   10'd623,
                  vs_a_ln:    10'd1,   vs_b_ln:    10'd313};
        end else begin
            w = '{blk_top_hi: 10'd9,   blk_mid_lo: 10'd264, blk_mid_hi: 10'd272,
                  blk_end_lo: 10'd1023, half_ln:   10'd263,
                  clp_a_lo:   10'd10,  clp_a_hi:   10'd263,
                  clp_b_lo:   10'd273, clp_b_hi:   10'd525,
                  vs_a_ln:    10'd4,   vs_b_ln:    10'd266};
        end
        return w;
    endfunction
endpackage

// File: rtl/raster_hcount.sv
// raster_hcount: pixel position within a line, wrapping at len-1.
// Assumes len >= 2 and fits in PIX_W bits.
module raster_hcount #(
    parameter int PIX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIX_W-1:0] len,
    output logic [PIX_W-1:0] h_cnt,
    output logic             line_end
);
    // Last pixel of the line (>= also recovers after a format change)
    assign line_end = (h_cnt >= len - 1'b1);

    // Pixel counter, reset to pixel 0
    always_ff @(posedge clk) begin
        if (!rst_n)        h_cnt <= '0;
        else if (line_end) h_cnt <= '0;
        else               h_cnt <= h_cnt + 1'b1;
    end

    assert_hwrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (h_cnt == '0));
endmodule

// File: rtl/raster_vcount.sv
// raster_vcount: line number in the frame and the field flag.
// Advances on line_end; starts at raster_pkg::RESET_LINE after reset.
module raster_vcount
    import raster_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  fmt_pal,
    input  logic  line_end,
    output line_t line_no,
    output logic  field
);
    line_t nxt_line;
    line_t eff_line;

    // Next line number with wrap to 1 after the last line
    always_comb begin
        nxt_line = (line_no >= last_line(fmt_pal)) ? line_t'(1) : line_no + 1'b1;
        eff_line = line_end ? nxt_line : line_no;
    end

    // Line register and field flag, kept consistent each clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_no <= RESET_LINE;
            field   <= 1'b0;
        end else begin
            if (line_end) line_no <= nxt_line;
            field <= (eff_line >= field_line(fmt_pal));
        end
    end

    assert_lwrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end && line_no == last_line(fmt_pal) && $stable(fmt_pal)) |=> (line_no == line_t'(1)));
    assert_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(fmt_pal) |-> (field == (line_no >= field_line(fmt_pal))));
endmodule

// File: rtl/raster_hsync.sv
// raster_hsync: places the active-low sync pulse within the line.
// Fall = (offset + len - HS_REF) mod len, limited to len-1. The pulse
// is HS_W wide and cut off at the line end. Assumes HS_REF <= len.
module raster_hsync #(
    parameter int PIX_W  = 10,
    parameter int OFF_W  = 10,
    parameter int HS_W   = 64,
    parameter int HS_REF = 126
) (
    input  logic [PIX_W-1:0] h_cnt,
    input  logic [PIX_W-1:0] len,
    input  logic [OFF_W-1:0] hs_offset,
    output logic             hs_n
);
    localparam int TW = ((OFF_W > PIX_W) ? OFF_W : PIX_W) + 2;

    logic [TW-1:0] len_x, h_x, raw, once, fall;

    // Fall position arithmetic and pulse window
    always_comb begin
        len_x = TW'(len);
        h_x   = TW'(h_cnt);
        raw   = TW'(hs_offset) + len_x - TW'(HS_REF);
        once  = (raw >= len_x) ? raw - len_x : raw;
        fall  = (once >= len_x) ? len_x - 1'b1 : once;
        hs_n  = !((h_x >= fall) && ((h_x - fall) < TW'(HS_W)));
    end
endmodule

// File: rtl/raster_vwin.sv
// raster_vwin: decodes the vertical gates and the field datum from the
// line and pixel counters, using the selected standard's line table.
module raster_vwin
    import raster_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             fmt_pal,
    input  logic             ped_en,
    input  line_t            line_no,
    input  logic [PIX_W-1:0] h_cnt,
    input  logic [PIX_W-1:0] len,
    output logic             vblank,
    output logic             clamp_gate,
    output logic             ped_win,
    output logic             vs
);
    win_lines_t w;
    logic [PIX_W-1:0] half;

    // Window comparisons for the active standard
    always_comb begin
        w    = win_lines(fmt_pal);
        half = len >> 1;
        vblank = (line_no <= w.blk_top_hi)
               | ((line_no >= w.blk_mid_lo) && (line_no <= w.blk_mid_hi))
               | (line_no >= w.blk_end_lo)
               | ((line_no == w.half_ln) && (h_cnt >= half));
        clamp_gate = ((line_no >= w.clp_a_lo) && (line_no <= w.clp_a_hi))
                   | ((line_no >= w.clp_b_lo) && (line_no <= w.clp_b_hi));
        ped_win = !fmt_pal && ped_en
                && (((line_no >= PED_A_LO) && (line_no <= PED_A_HI))
                 || ((line_no >= PED_B_LO) && (line_no <= PED_B_HI)));
        vs = ((line_no == w.vs_a_ln) && (h_cnt == '0))
           | ((line_no == w.vs_b_ln) && (h_cnt == half));
    end
endmodule

// File: rtl/raster_timing_gen.sv
// raster_timing_gen: master raster timing for 525- and 625-line video.
// Counters are registered; all timing outputs decode from them in the
// same cycle. Assumes HS_REF <= both line lengths < 2**PIX_W.
module raster_timing_gen
    import raster_pkg::*;
#(
    parameter int L_NTSC = 858,
    parameter int L_PAL  = 864,
    parameter int PIX_W  = 10,
    parameter int OFF_W  = 10,
    parameter int HS_W   = 64,
    parameter int HS_REF = 126
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_pal,
    input  logic             ped_en,
    input  logic [OFF_W-1:0] hs_offset,
    output logic             hs_n,
    output logic             vs,
    output logic             field,
    output logic             vblank,
    output logic             clamp_gate,
    output logic             ped_win,
    output logic [LINE_W-1:0] line_num,
    output logic [PIX_W-1:0] pix_pos
);
    logic [PIX_W-1:0] len;
    logic             line_end;

    // Line length of the selected standard
    assign len = fmt_pal ? PIX_W'(L_PAL) : PIX_W'(L_NTSC);

    raster_hcount #(.PIX_W(PIX_W)) u_hcount (
        .clk(clk), .rst_n(rst_n), .len(len), .h_cnt(pix_pos), .line_end(line_end)
    );

    raster_vcount u_vcount (
        .clk(clk), .rst_n(rst_n), .fmt_pal(fmt_pal), .line_end(line_end),
        .line_no(line_num), .field(field)
    );

    raster_hsync #(.PIX_W(PIX_W), .OFF_W(OFF_W), .HS_W(HS_W), .HS_REF(HS_REF)) u_hsync (
        .h_cnt(pix_pos), .len(len), .hs_offset(hs_offset), .hs_n(hs_n)
    );

    raster_vwin #(.PIX_W(PIX_W)) u_vwin (
        .fmt_pal(fmt_pal), .ped_en(ped_en), .line_no(line_num), .h_cnt(pix_pos), .len(len),
        .vblank(vblank), .clamp_gate(clamp_gate), .ped_win(ped_win), .vs(vs)
    );

    // Length of the current low run of hs_n, for the width check
    logic [PIX_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || hs_n) low_run <= '0;
        else                low_run <= low_run + 1'b1;
    end

    assert_hs_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run < PIX_W'(HS_W)) || hs_n);
    assert_vs_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        vs |=> !vs);
    assert_ped_pal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_pal |-> !ped_win);
    assert_line_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(line_num) || pix_pos == '0));
endmodule

// File: tb/test_raster_timing_gen.sv
// Bench: small line lengths, full frames and an offset sweep, with every
// output compared each clock against a position model in the bench.
module test_raster_timing_gen;
    localparam int LN = 40, LP = 44, HW = 8, REF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fmt_pal = 1'b0;
    logic ped_en = 1'b0;
    logic [9:0] hs_offset = 10'd10;
    logic hs_n, vs, field, vblank, clamp_gate, ped_win;
    logic [9:0] line_num;
    logic [9:0] pix_pos;

    int vectors = 0;
    int fails = 0;
    int mh, ml;

    always #4 clk = ~clk;

    raster_timing_gen #(.L_NTSC(LN), .L_PAL(LP), .PIX_W(10), .OFF_W(10),
                        .HS_W(HW), .HS_REF(REF)) i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .fmt_pal(fmt_pal), .ped_en(ped_en),
        .hs_offset(hs_offset), .hs_n(hs_n), .vs(vs), .field(field),
        .vblank(vblank), .clamp_gate(clamp_gate), .ped_win(ped_win),
        .line_num(line_num), .pix_pos(pix_pos)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (line %0d pix %0d)",
                     tag, what, act, exp, ml, mh);
        end
    endtask

    function automatic int e_len(input bit pal);
        return pal ? LP : LN;
    endfunction

    function automatic bit e_hs_n(input bit pal, input int h, input int off);
        int l = e_len(pal);
        int f = off + l - REF;
        if (f >= l) f -= l;
        if (f >= l) f = l - 1;
        return !(h >= f && (h - f) < HW);
    endfunction

    function automatic bit e_vblank(input bit pal, input int l, input int h);
        int hf = e_len(pal) / 2;
        if (pal) return (l <= 5) || (l >= 311 && l <= 318) || (l >= 624) || (l == 623 && h >= hf);
        return (l <= 9) || (l >= 264 && l <= 272) || (l == 263 && h >= hf);
    endfunction

    function automatic bit e_clamp(input bit pal, input int l);
        if (pal) return (l >= 6 && l <= 310) || (l >= 319 && l <= 623);
        return (l >= 10 && l <= 263) || (l >= 273 && l <= 525);
    endfunction

    function automatic bit e_ped(input bit pal, input bit pe, input int l);
        return !pal && pe && ((l >= 23 && l <= 262) || (l >= 286 && l <= 525));
    endfunction

    function automatic bit e_vs(input bit pal, input int l, input int h);
        int hf = e_len(pal) / 2;
        if (pal) return (l == 1 && h == 0) || (l == 313 && h == hf);
        return (l == 4 && h == 0) || (l == 266 && h == hf);
    endfunction

    task automatic compare_all(input string rtag);
        bit pal = fmt_pal;
        chk(rtag == "" ? "R1" : rtag, "pix_pos", int'(pix_pos), mh);
        chk(rtag == "" ? "R2" : rtag, "line_num", int'(line_num), ml);
        chk("R3", "field", int'(field), int'(ml >= (pal ? 313 : 264)));
        chk(pal ? "R5" : "R4", "vblank", int'(vblank), int'(e_vblank(pal, ml, mh)));
        chk("R6", "clamp_gate", int'(clamp_gate), int'(e_clamp(pal, ml)));
        chk("R7", "ped_win", int'(ped_win), int'(e_ped(pal, ped_en, ml)));
        chk("R8", "hs_n", int'(hs_n), int'(e_hs_n(pal, mh, int'(hs_offset))));
        chk("R10", "vs", int'(vs), int'(e_vs(pal, ml, mh)));
    endtask

    // Reset, check the reset position, then run n clocks with per-clock checks
    task automatic run_seg(input bit pal, input bit pe, input int off, input int n);
        @(negedge clk);
        rst_n = 1'b0;
        fmt_pal = pal;
        ped_en = pe;
        hs_offset = 10'(off);
        repeat (3) @(posedge clk);
        @(negedge clk);
        mh = 0;
        ml = 64;
        compare_all("R11");
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mh == e_len(pal) - 1) begin
                mh = 0;
                ml = (ml == (pal ? 625 : 525)) ? 1 : ml + 1;
            end else begin
                mh++;
            end
            compare_all("");
        end
    endtask

    initial begin
        // Whole frames in each format; pedestal on and off; PAL pedestal ignored
        run_seg(1'b0, 1'b0, 10, 525 * LN + 200);
        run_seg(1'b0, 1'b1, 40, 525 * LN + 200);
        run_seg(1'b1, 1'b1, 5, 625 * LP + 200);
        // Offset sweep: normal, cut-off (R9) and limited fall positions
        for (int o = 0; o < 128; o++) run_seg(1'b0, 1'b0, o, 2 * LN);
        run_seg(1'b0, 1'b0, 1023, 2 * LN);
        run_seg(1'b1, 1'b0, 1023, 2 * LP);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule